// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the serial front end of a two-wire EEPROM slave. It watches the clock and data lines, which have already been synchronized to the system clock. From them it finds bus Start and Stop conditions and takes in bytes on rising clock edges. It answers an addressed master by pulling the data line low. The memory array and the write-cycle timer sit in neighbouring blocks. They see only a small strobe interface: a word-address load, a write-data strobe, a write commit, a read request, and a busy flag that they drive.

The block keeps the 17-bit word pointer itself. The device-address byte selects the chip through two strap inputs and also carries the top bit of the word address. Two more address bytes follow. Write data advances the pointer inside a 256-byte page. Read data advances it across the whole space. A write that carries only an address, followed by a repeated Start and a read, becomes a random read. A read with no address phase continues from wherever the pointer stands.

Top module: `ee_slave_engine`

## Requirements
- R1: A Start (data falling while clock is high) restarts reception of a device-address byte from any state, and a Stop (data rising while clock is high) returns the block to idle. Either one arriving in the middle of a byte discards that byte without any strobe.
- R2: The device-address byte is received MSB first as: bits 7:4 equal 1010, bits 3:2 equal strap_i[1:0], bit 1 is the page bit, and bit 0 selects read when 1 and write when 0. On a match the block pulls SDA low through the 9th clock. On any mismatch it does not acknowledge and ignores the bus until the next Start.
- R3: After a write device address, two bytes (high, then low) are each acknowledged. Acknowledging the low byte pulses addr_load_o for one cycle with addr_o equal to {page bit, high byte, low byte}.
- R4: Each further write byte is acknowledged and pulses wr_strobe_o for one cycle, with wr_data_o holding the byte and addr_o holding its target. The pointer then increments in its low 8 bits only, so the byte after the last one of a page lands on the first byte of the same page.
- R5: A Stop after at least one write data byte pulses wr_commit_o for one cycle. A Stop with no data byte, a Stop after only the high address byte, and a repeated Start after data bytes all give no commit. An unfinished address phase leaves the pointer unchanged.
- R6: A read device address is acknowledged and starts a read at the current pointer. Its page bit is ignored. Each byte is sent MSB first. For each byte, rd_req_o pulses for one cycle with addr_o holding the address, and rd_data_i is taken in the following cycle.
- R7: A write device address plus two address bytes, followed by a repeated Start and a read device address, reads from the address just loaded.
- R8: A master ACK on the 9th clock of a read byte sends the byte at the next address, and 0x1FFFF is followed by 0x00000. A master NACK ends the read with SDA released. After any read the pointer stands one past the last byte sent.
- R9: When busy_i is high at the end of any received byte, the block does not acknowledge, raises no strobe and returns to idle. This includes a matching device address.
- R10: sda_low_o changes only in the cycle after a falling SCL edge, so the block never moves SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (bus level) |
| strap_i | input | 2 | Chip-select straps compared with address bits 3:2 |
| busy_i | input | 1 | Write cycle in progress; block stays silent |
| sda_low_o | output | 1 | Open-drain pull-down enable for SDA |
| addr_o | output | 17 | Current word pointer |
| addr_load_o | output | 1 | One-cycle pulse: pointer loaded from address bytes |
| wr_strobe_o | output | 1 | One-cycle pulse: write byte for addr_o |
| wr_data_o | output | 8 | Write byte, valid with wr_strobe_o |
| wr_commit_o | output | 1 | One-cycle pulse: write sequence closed by Stop |
| rd_req_o | output | 1 | One-cycle pulse: read byte at addr_o |
| rd_data_i | input | 8 | Read byte, valid the cycle after rd_req_o |

## Verification
Directed cases cover the following:
- straps that differ from the address, and a wrong fixed code, which separates a correct match from a loose one;
- a write with the page bit set that is read back through a current read with the page bit clear, which shows the bit is used on writes and ignored on reads;
- a write run across a page end against a sequential read across the same address range, which tells page-local wrap from full-space increment;
- a read over 0x1FFFF, which shows the full-space wrap.

Aborted phases, early Stops and busy cycles are checked at the strobe and acknowledge pins. Random writes and read-backs at random addresses and straps, with lengths of one to five bytes, are compared against a bench model of the pointer and the memory.

// File: rtl/ee_slv_pkg.sv
package ee_slv_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    localparam logic [CNT_W-1:0] SLOT_ACK  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] SLOT_DONE = CNT_W'(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } eng_st_e;

    typedef struct packed {
        eng_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] hi;
        logic              pbit;
        logic              drive;
        logic              wrote;
        logic              ld;
        logic              wr;
        logic              rd_req;
        logic              rd_wait;
        logic              commit;
    } eng_s;
endpackage

// File: rtl/ee_line_events.sv
module ee_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_d, scl_q;
    logic sda_d, sda_q;

    always_comb begin
        scl_d = scl_i;
        sda_d = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    // Bus conditions need SCL high in both the previous and current sample.
    assign rise_o  = !scl_q && scl_i;
    assign fall_o  = scl_q && !scl_i;
    assign start_o = scl_q && scl_i && sda_q && !sda_i;
    assign stop_o  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/ee_word_ptr.sv
module ee_word_ptr #(
    parameter int W      = 17,
    parameter int PAGE_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_page_i,
    input  logic         inc_all_i,
    output logic [W-1:0] ptr_o
);
    localparam logic [W-1:0] LOW_MASK = W'((64'd1 << PAGE_W) - 64'd1);

    logic [W-1:0] ptr_d, ptr_q;
    logic [W-1:0] ptr_plus;

    always_comb begin
        ptr_plus = ptr_q + W'(1);
        ptr_d    = ptr_q;
        if (load_i) begin
            ptr_d = load_val_i;
        end else if (inc_all_i) begin
            ptr_d = ptr_plus;
        end else if (inc_page_i) begin
            // Only the in-page bits advance; the page number is kept.
            ptr_d = (ptr_q & ~LOW_MASK) | (ptr_plus & LOW_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/ee_slave_engine.sv
module ee_slave_engine
    import ee_slv_pkg::*;
#(
    parameter int         PAGE_W   = 8,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    input  logic              busy_i,
    output logic              sda_low_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_load_o,
    output logic              wr_strobe_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              wr_commit_o,
    output logic              rd_req_o,
    input  logic [BYTE_W-1:0] rd_data_i
);
    logic ev_rise, ev_fall, ev_start, ev_stop;
    logic ptr_load, ptr_inc_page, ptr_inc_all;
    logic [ADDR_W-1:0] ptr_val;
    eng_s q, n;

    ee_line_events u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .rise_o (ev_rise),
        .fall_o (ev_fall),
        .start_o(ev_start),
        .stop_o (ev_stop)
    );

    ee_word_ptr #(
        .W     (ADDR_W),
        .PAGE_W(PAGE_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ptr_load),
        .load_val_i(ptr_val),
        .inc_page_i(ptr_inc_page),
        .inc_all_i (ptr_inc_all),
        .ptr_o     (addr_o)
    );

    assign ptr_val = {q.pbit, q.hi, q.rx};

    always_comb begin
        n            = q;
        n.ld         = 1'b0;
        n.wr         = 1'b0;
        n.rd_req     = 1'b0;
        n.commit     = 1'b0;
        n.rd_wait    = q.rd_req;
        ptr_load     = 1'b0;
        ptr_inc_page = 1'b0;
        ptr_inc_all  = 1'b0;

        // Read data returns one cycle after the request.
        if (q.rd_wait) n.tx = rd_data_i;

        if (ev_start) begin
            n.st    = ST_DEV;
            n.cnt   = '0;
            n.drive = 1'b0;
            n.wrote = 1'b0;
        end else if (ev_stop) begin
            n.commit = q.wrote;
            n.st     = ST_IDLE;
            n.cnt    = '0;
            n.drive  = 1'b0;
            n.wrote  = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                end
                ST_RDAT: begin
                    if (ev_rise) begin
                        if (q.cnt < SLOT_ACK) begin
                            n.cnt = q.cnt + CNT_W'(1);
                        end else if (q.cnt == SLOT_ACK) begin
                            ptr_inc_all = 1'b1;
                            if (!sda_i) begin
                                n.cnt    = SLOT_DONE;
                                n.rd_req = 1'b1;
                            end else begin
                                n.st  = ST_IDLE;
                                n.cnt = '0;
                            end
                        end
                    end else if (ev_fall) begin
                        if (q.cnt != '0 && q.cnt < SLOT_ACK) begin
                            n.tx    = {q.tx[BYTE_W-2:0], 1'b0};
                            n.drive = !q.tx[BYTE_W-2];
                        end else if (q.cnt == SLOT_ACK) begin
                            n.drive = 1'b0;
                        end else if (q.cnt == SLOT_DONE) begin
                            n.cnt   = '0;
                            n.drive = !q.tx[BYTE_W-1];
                        end
                    end
                end
                default: begin
                    if (ev_rise) begin
                        if (q.cnt < SLOT_ACK) begin
                            n.rx  = {q.rx[BYTE_W-2:0], sda_i};
                            n.cnt = q.cnt + CNT_W'(1);
                        end else if (q.cnt == SLOT_ACK) begin
                            n.cnt = SLOT_DONE;
                        end
                    end else if (ev_fall) begin
                        if (q.cnt == SLOT_ACK) begin
                            if (busy_i) begin
                                n.st    = ST_IDLE;
                                n.cnt   = '0;
                                n.wrote = 1'b0;
                            end else begin
                                case (q.st)
                                    ST_DEV: begin
                                        if (q.rx[7:4] == DEV_CODE && q.rx[3:2] == strap_i) begin
                                            n.drive = 1'b1;
                                            if (q.rx[0]) n.rd_req = 1'b1;
                                            else         n.pbit   = q.rx[1];
                                        end else begin
                                            n.st  = ST_IDLE;
                                            n.cnt = '0;
                                        end
                                    end
                                    ST_AHI: begin
                                        n.hi    = q.rx;
                                        n.drive = 1'b1;
                                    end
                                    ST_ALO: begin
                                        ptr_load = 1'b1;
                                        n.ld     = 1'b1;
                                        n.drive  = 1'b1;
                                    end
                                    default: begin
                                        n.wr    = 1'b1;
                                        n.wrote = 1'b1;
                                        n.drive = 1'b1;
                                    end
                                endcase
                            end
                        end else if (q.cnt == SLOT_DONE) begin
                            n.cnt   = '0;
                            n.drive = 1'b0;
                            case (q.st)
                                ST_DEV: begin
                                    if (q.rx[0]) begin
                                        n.st    = ST_RDAT;
                                        n.drive = !q.tx[BYTE_W-1];
                                    end else begin
                                        n.st = ST_AHI;
                                    end
                                end
                                ST_AHI:  n.st = ST_ALO;
                                ST_ALO:  n.st = ST_WDAT;
                                default: ptr_inc_page = 1'b1;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign sda_low_o   = q.drive;
    assign addr_load_o = q.ld;
    assign wr_strobe_o = q.wr;
    assign wr_data_o   = q.rx;
    assign wr_commit_o = q.commit;
    assign rd_req_o    = q.rd_req;
endmodule

// File: rtl/ee_slave_engine_chk.sv
module ee_slave_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic busy_i,
    input logic sda_low_o,
    input logic addr_load_o,
    input logic wr_strobe_o,
    input logic wr_commit_o,
    input logic rd_req_o
);
    // R10: the pull-down moves only right after SCL was low
    a_r10_drive_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_o) |-> !$past(scl_i));

    // R3 / R4 / R5 / R6: memory-side strobes never overlap
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_load_o, wr_strobe_o, wr_commit_o, rd_req_o}));

    // R6: a read request lasts one cycle
    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R5: a commit lasts one cycle
    a_r5_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |=> !wr_commit_o);

    // R9: no address load or write byte is issued out of a busy cycle
    a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe_o || addr_load_o) |-> !$past(busy_i));
endmodule

bind ee_slave_engine ee_slave_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .busy_i     (busy_i),
    .sda_low_o  (sda_low_o),
    .addr_load_o(addr_load_o),
    .wr_strobe_o(wr_strobe_o),
    .wr_commit_o(wr_commit_o),
    .rd_req_o   (rd_req_o)
);

// File: tb/tb_ee_slave_engine.sv
`timescale 1ns/1ps
module tb_ee_slave_engine;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic [1:0]  strap = 2'b00;
    logic        sda_low, addr_load, wr_strobe, wr_commit, rd_req;
    logic [16:0] addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data = 8'h00;
    wire         sda_bus = sda_m & ~sda_low;

    ee_slave_engine dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .busy_i     (busy),
        .sda_low_o  (sda_low),
        .addr_o     (addr),
        .addr_load_o(addr_load),
        .wr_strobe_o(wr_strobe),
        .wr_data_o  (wr_data),
        .wr_commit_o(wr_commit),
        .rd_req_o   (rd_req),
        .rd_data_i  (rd_data)
    );

    logic [7:0]  mem   [int];
    logic [7:0]  exp_m [int];
    logic [7:0]  wbuf  [8];
    logic [16:0] bptr = '0;
    logic [16:0] last_load = '0;
    int n_load = 0, n_wr = 0, n_commit = 0, viol = 0;
    int checks = 0, fails = 0;
    logic last_low = 1'b0;

    // Memory-side model and port monitors
    always @(posedge clk) begin
        if (wr_strobe) begin
            mem[int'(addr)] = wr_data;
            n_wr++;
        end
        if (rd_req) rd_data <= mem.exists(int'(addr)) ? mem[int'(addr)] : 8'hFF;
        if (addr_load) begin
            n_load++;
            last_load = addr;
        end
        if (wr_commit) n_commit++;
        if (rst_n) begin
            if (sda_low !== last_low && scl_m) viol++;
            last_low = sda_low;
        end
    end

    function automatic logic [7:0] exp_get(input logic [16:0] a);
        return exp_m.exists(int'(a)) ? exp_m[int'(a)] : 8'hFF;
    endfunction

    function automatic logic [16:0] page_next(input logic [16:0] a, input int k);
        return {a[16:8], 8'(int'(a[7:0]) + k)};
    endfunction

    task automatic preload(input logic [16:0] a, input logic [7:0] d);
        mem[int'(a)]   = d;
        exp_m[int'(a)] = d;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic m_start();
        scl_m = 1'b0; wait_n(H);
        sda_m = 1'b1; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic m_stop();
        scl_m = 1'b0; wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        sda_m = 1'b1; wait_n(H);
    endtask

    task automatic m_bit(input logic b, output logic r);
        wait_n(2);
        sda_m = b;
        wait_n(H);
        scl_m = 1'b1;
        wait_n(H / 2);
        r = sda_bus;
        wait_n(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic m_wbyte(input logic [7:0] d, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, r);
        ack = (r == 1'b0);
    endtask

    task automatic m_rbyte(input bit mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(mack ? 1'b0 : 1'b1, r);
    endtask

    task automatic wr_txn(input logic [16:0] a, input int n, input bit do_stop, input string req);
        bit ak;
        m_start();
        m_wbyte({4'b1010, strap, a[16], 1'b0}, ak);
        chk(req, "write device address ack", 32'(ak), 32'd1);
        m_wbyte(a[15:8], ak);
        chk(req, "high address ack", 32'(ak), 32'd1);
        m_wbyte(a[7:0], ak);
        chk(req, "low address ack", 32'(ak), 32'd1);
        for (int i = 0; i < n; i++) begin
            m_wbyte(wbuf[i], ak);
            chk(req, "data ack", 32'(ak), 32'd1);
            exp_m[int'(page_next(a, i))] = wbuf[i];
        end
        bptr = page_next(a, n);
        if (do_stop) m_stop();
    endtask

    task automatic rd_bytes(input int n, input logic [16:0] p, input logic pb, input string req);
        bit ak;
        logic [7:0] d;
        m_wbyte({4'b1010, strap, pb, 1'b1}, ak);
        chk(req, "read device address ack", 32'(ak), 32'd1);
        for (int i = 0; i < n; i++) begin
            m_rbyte(i != n - 1, d);
            chk(req, "read data", 32'(d), 32'(exp_get(17'(p + 17'(i)))));
        end
        m_stop();
        bptr = 17'(p + 17'(n));
    endtask

    task automatic rand_rd(input logic [16:0] a, input int n, input string req);
        bit ak;
        m_start();
        m_wbyte({4'b1010, strap, a[16], 1'b0}, ak);
        m_wbyte(a[15:8], ak);
        m_wbyte(a[7:0], ak);
        chk(req, "dummy write ack", 32'(ak), 32'd1);
        m_start();
        rd_bytes(n, a, 1'b0, req);
    endtask

    task automatic cur_rd(input int n, input logic pb, input string req);
        m_start();
        rd_bytes(n, bptr, pb, req);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit ak;
        logic r;
        int l0, c0, w0;
        void'($urandom(32'd7319));
        wait_n(5);
        chk("R1", "reset sda_low", 32'(sda_low), 0);
        chk("R1", "reset addr", 32'(addr), 0);
        chk("R1", "reset strobes", 32'({addr_load, wr_strobe, wr_commit, rd_req}), 0);
        rst_n = 1'b1;
        wait_n(4);

        // R2: strap mismatch and wrong fixed code
        strap = 2'b10;
        m_start(); m_wbyte({4'b1010, 2'b01, 2'b00}, ak); m_stop();
        chk("R2", "strap mismatch ack", 32'(ak), 0);
        m_start(); m_wbyte({4'b1011, 2'b10, 2'b00}, ak); m_stop();
        chk("R2", "wrong code ack", 32'(ak), 0);

        // R2 / R3 / R5: byte write with page bit set
        l0 = n_load; c0 = n_commit;
        wbuf[0] = 8'hC3;
        wr_txn(17'h12345, 1, 1'b1, "R3");
        chk("R3", "load count", 32'(n_load - l0), 1);
        chk("R3", "loaded address", 32'(last_load), 32'h12345);
        chk("R5", "commit after data", 32'(n_commit - c0), 1);

        // R7 random read, R6 current read with page bit clear
        preload(17'h12346, 8'h77);
        rand_rd(17'h12345, 1, "R7");
        cur_rd(1, 1'b0, "R6");

        // R4: page wrap on write, checked by a full-space sequential read
        preload(17'h04200, 8'h5A);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        w0 = n_wr;
        wr_txn(17'h041FE, 4, 1'b1, "R4");
        chk("R4", "write strobes", 32'(n_wr - w0), 4);
        rand_rd(17'h041FE, 3, "R4");
        rand_rd(17'h04100, 2, "R4");

        // R8: sequential read across the top of the space
        preload(17'h1FFFE, 8'hA1); preload(17'h1FFFF, 8'hA2);
        preload(17'h00000, 8'hA3); preload(17'h00001, 8'hA4); preload(17'h00002, 8'hA5);
        rand_rd(17'h1FFFE, 4, "R8");
        cur_rd(1, 1'b1, "R8");

        // R5: address-only write, partial address, start after data
        l0 = n_load; c0 = n_commit; w0 = n_wr;
        wr_txn(17'h00321, 0, 1'b1, "R5");
        chk("R5", "address-only load", 32'(n_load - l0), 1);
        chk("R5", "address-only commit", 32'(n_commit - c0), 0);
        m_start(); m_wbyte({4'b1010, strap, 2'b00}, ak); m_wbyte(8'h07, ak); m_stop();
        chk("R5", "partial address load", 32'(n_load - l0), 1);
        cur_rd(1, 1'b0, "R5");
        c0 = n_commit;
        wbuf[0] = 8'h9E;
        wr_txn(17'h00500, 1, 1'b0, "R5");
        cur_rd(1, 1'b0, "R5");
        chk("R5", "start after data commit", 32'(n_commit - c0), 0);

        // R1: Start and Stop mid-byte
        w0 = n_wr; c0 = n_commit;
        m_start();
        for (int i = 0; i < 4; i++) m_bit(1'b1, r);
        wbuf[0] = 8'h3C;
        wr_txn(17'h00610, 1, 1'b1, "R1");
        chk("R1", "restart then write", 32'(n_wr - w0), 1);
        m_start(); m_wbyte({4'b1010, strap, 2'b00}, ak); m_wbyte(8'h06, ak); m_wbyte(8'h20, ak);
        for (int i = 0; i < 4; i++) m_bit(1'b0, r);
        m_stop();
        chk("R1", "stop mid-byte strobes", 32'(n_wr - w0), 1);
        chk("R1", "stop mid-byte commit", 32'(n_commit - c0), 1);
        bptr = 17'h00620;

        // R9: busy blocks matching address and later bytes
        busy = 1'b1;
        m_start(); m_wbyte({4'b1010, strap, 2'b00}, ak); m_stop();
        chk("R9", "busy device ack", 32'(ak), 0);
        busy = 1'b0;
        l0 = n_load;
        m_start(); m_wbyte({4'b1010, strap, 2'b00}, ak); m_wbyte(8'h01, ak);
        busy = 1'b1;
        m_wbyte(8'h02, ak);
        chk("R9", "busy low byte ack", 32'(ak), 0);
        m_stop();
        busy = 1'b0;
        chk("R9", "busy load count", 32'(n_load - l0), 0);
        cur_rd(1, 1'b0, "R9");

        // Random writes and read-backs
        for (int it = 0; it < 20; it++) begin
            logic [16:0] a;
            int n;
            strap = 2'($urandom);
            a = 17'($urandom);
            n = 1 + int'($urandom % 5);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            wr_txn(a, n, 1'b1, "R4");
            rand_rd(a, n, "R8");
        end

        chk("R10", "sda moved while scl high", 32'(viol), 0);
        finish_run();
    end
endmodule